// File: doc/BRIEF.md
# Iterative Word Divider with Signed and Unsigned Modes

This block performs 32-bit integer division for the two word-divide operations of a RISC integer pipeline. It receives a whole instruction word beside its two source operands, decodes whether the instruction is a word divide, and picks signed or unsigned arithmetic from the extended opcode field. The quotient, an overflow flag and a three-bit sign comparison of the quotient are returned after a fixed latency of 20 clock cycles, whatever the operands.

Operands enter on a valid/ready pair. `in_ready` is high exactly when no divide is in flight. A request is taken on a rising edge where `in_valid` and `in_ready` are both high and the instruction decodes as a word divide. Anything offered while `in_ready` is low is dropped, not held, so the caller keeps the request up until it sees `in_ready`. The result side has no back-pressure: `out_valid` is a one-cycle pulse and the result outputs then hold until the next pulse.

Inside, the magnitudes of the operands go to a restoring divider that retires two quotient bits per cycle. The quotient is negated when the operand signs differ, and it is forced to zero for the exception cases.

Top module: `word_divider`

## Requirements
- R1: A request is accepted only when `instr[31:26]` equals 31 and `instr[9:1]` equals 459 or 491. Any other instruction word gives no `out_valid` and leaves `in_ready` high.
- R2: With `instr[9:1]` = 459 the operands are unsigned and `quotient` is the truncated unsigned quotient of `op_a` by `op_b`.
- R3: With `instr[9:1]` = 491 the operands are two's complement and `quotient` is the signed quotient, truncated toward zero.
- R4: `out_valid` rises exactly 20 rising edges after the accepting edge, for every operand value and both modes.
- R5: `in_ready` is low from the accepting edge until `out_valid` rises. `in_valid` is ignored while `in_ready` is low. `out_valid` lasts one cycle.
- R6: A divisor of zero, and a signed 0x80000000 divided by 0xFFFFFFFF, give a quotient of 0. `ovf` is 1 only in these cases and only when `instr[10]` is set.
- R7: When `instr[0]` is set, `cmp_flags` holds the signed comparison of the quotient with zero: bit 2 for less, bit 1 for greater, bit 0 for equal. When `instr[0]` is clear, `cmp_flags` is 000.
- R8: After reset `in_ready` is 1, while `out_valid`, `quotient`, `ovf` and `cmp_flags` are 0.
- R9: `quotient`, `ovf` and `cmp_flags` change only on a cycle where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Divider idle, request can be taken |
| instr | input | 32 | Instruction word; bit 0 is the least significant |
| op_a | input | 32 | Dividend |
| op_b | input | 32 | Divisor |
| out_valid | output | 1 | One-cycle pulse: result outputs are new |
| quotient | output | 32 | Quotient |
| ovf | output | 1 | Overflow flag |
| cmp_flags | output | 3 | {less, greater, equal} versus zero, or 000 |

## Verification
Some properties are checked on every cycle. These are the single-cycle result pulse, `in_ready` being high while the pulse is up, the result outputs holding between pulses, a zero quotient whenever `ovf` is set, at most one comparison bit, and an acceptance-to-result distance of exactly 20 edges, measured by an independent counter. The arithmetic itself can only be shown by the bench's scenarios. These cover unsigned and signed quotients for each sign mix, truncation toward zero, values with the top bit set, and both exception cases with the overflow form on and off. The bench also shows that foreign opcodes are dropped and that a request made while busy is lost and does not disturb the divide in flight.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [5:0] MAJOR_DIV = 6'd31;
  localparam logic [8:0] MINOR_UNS = 9'd459;
  localparam logic [8:0] MINOR_SGN = 9'd491;

  typedef struct packed {
    logic sgn;   // two's complement operands
    logic oe;    // overflow flag requested
    logic rc;    // comparison flags requested
  } wdiv_ctl_t;
endpackage

// File: rtl/wdiv_decode.sv
module wdiv_decode
  import wdiv_pkg::*;
(
  input  logic [31:0] instr,
  output logic        hit,
  output wdiv_ctl_t   ctl
);
  logic [5:0] major;
  logic [8:0] minor;
  logic       unused_fields;

  assign major = instr[31:26];
  assign minor = instr[9:1];
  assign unused_fields = ^instr[25:11];

  always_comb begin
    hit     = (major == MAJOR_DIV) && ((minor == MINOR_UNS) || (minor == MINOR_SGN));
    ctl.sgn = (minor == MINOR_SGN);
    ctl.oe  = instr[10];
    ctl.rc  = instr[0];
  end
endmodule

// File: rtl/wdiv_iter.sv
module wdiv_iter #(
  parameter int unsigned W        = 32,
  parameter int unsigned BITS_CYC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo
);
  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic [W-1:0] rem_c [BITS_CYC+1];
  logic [W-1:0] quo_c [BITS_CYC+1];

  assign rem_c[0] = rem_q;
  assign quo_c[0] = quo_q;

  for (genvar g = 0; g < BITS_CYC; g++) begin : g_stage
    logic [W:0] shifted;
    logic       fits;
    assign shifted = {rem_c[g], quo_c[g][W-1]};
    assign fits    = shifted >= {1'b0, dvs_q};
    assign rem_c[g+1] = fits ? W'(shifted - {1'b0, dvs_q}) : shifted[W-1:0];
    assign quo_c[g+1] = {quo_c[g][W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
    end else if (step) begin
      rem_q <= rem_c[BITS_CYC];
      quo_q <= quo_c[BITS_CYC];
    end
  end

  assign quo = quo_q;

  // R2: a partial remainder never reaches the divisor once it is nonzero
  a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/wdiv_post.sv
module wdiv_post
  import wdiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] mag_quo,
  input  logic         negate,
  input  logic         excp,
  input  wdiv_ctl_t    ctl,
  output logic [W-1:0] quo,
  output logic         ovf,
  output logic [2:0]   flags
);
  logic [W-1:0] signed_quo;

  always_comb begin
    signed_quo = negate ? W'(-mag_quo) : mag_quo;
    quo        = excp ? '0 : signed_quo;
    ovf        = excp & ctl.oe;
    if (ctl.rc)
      flags = {quo[W-1], ~quo[W-1] & (|quo), ~(|quo)};
    else
      flags = 3'b000;
  end
endmodule

// File: rtl/word_divider.sv
module word_divider
  import wdiv_pkg::*;
#(
  parameter int unsigned LATENCY  = 20,
  parameter int unsigned BITS_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] instr,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  output logic        out_valid,
  output logic [31:0] quotient,
  output logic        ovf,
  output logic [2:0]  cmp_flags
);
  localparam int unsigned STEPS = WORD_W / BITS_CYC;
  localparam int unsigned CW    = $clog2(LATENCY + 2);

  logic          hit, accept, step, finish;
  wdiv_ctl_t     dec_ctl, ctl_q;
  logic          busy_q, neg_q, excp_q;
  logic [CW-1:0] cnt_q;
  logic [31:0]   mag_a, mag_b, raw_quo, fin_quo;
  logic          fin_ovf;
  logic [2:0]    fin_flags;

  wdiv_decode u_dec (.instr(instr), .hit(hit), .ctl(dec_ctl));

  assign in_ready = ~busy_q;
  assign accept   = in_valid & ~busy_q & hit;
  assign mag_a    = (dec_ctl.sgn & op_a[31]) ? 32'(-op_a) : op_a;
  assign mag_b    = (dec_ctl.sgn & op_b[31]) ? 32'(-op_b) : op_b;
  assign step     = busy_q && (cnt_q <= CW'(STEPS));
  assign finish   = busy_q && (cnt_q == CW'(LATENCY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ctl_q  <= '0;
      neg_q  <= 1'b0;
      excp_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(1);
      ctl_q  <= dec_ctl;
      neg_q  <= dec_ctl.sgn & (op_a[31] ^ op_b[31]);
      excp_q <= (op_b == '0) ||
                (dec_ctl.sgn && (op_a == 32'h8000_0000) && (op_b == 32'hFFFF_FFFF));
    end else if (finish) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  wdiv_iter #(.W(WORD_W), .BITS_CYC(BITS_CYC)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
    .dividend(mag_a), .divisor(mag_b), .quo(raw_quo)
  );

  wdiv_post #(.W(WORD_W)) u_post (
    .mag_quo(raw_quo), .negate(neg_q), .excp(excp_q), .ctl(ctl_q),
    .quo(fin_quo), .ovf(fin_ovf), .flags(fin_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      quotient  <= '0;
      ovf       <= 1'b0;
      cmp_flags <= '0;
    end else begin
      out_valid <= finish;
      if (finish) begin
        quotient  <= fin_quo;
        ovf       <= fin_ovf;
        cmp_flags <= fin_flags;
      end
    end
  end

  // independent distance counter for the latency check
  logic [CW:0] chk_dist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        chk_dist <= '0;
    else if (in_valid && in_ready && hit) chk_dist <= (CW+1)'(1);
    else if (out_valid)                chk_dist <= '0;
    else if (chk_dist != '0)           chk_dist <= chk_dist + (CW+1)'(1);
  end

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (chk_dist == (CW+1)'(LATENCY + 1)));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r5_ready_at_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
  a_r6_zero_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (quotient == '0));
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmp_flags));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> $stable(quotient) || out_valid);
endmodule

// File: tb/sim_word_divider.sv
`timescale 1ns/100ps
module sim_word_divider;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, ovf;
  logic [31:0] instr = '0, op_a = '0, op_b = '0, quotient;
  logic [2:0] cmp_flags;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  word_divider u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .quotient(quotient), .ovf(ovf), .cmp_flags(cmp_flags));

  // {sgn, oe, rc, a, b, q, ovf, flags}
  localparam int NV = 12;
  localparam logic [102:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,32'd100,       32'd7,          32'd14,          1'b0,3'b010},
    {1'b0,1'b0,1'b1,32'hFFFFFFFF,  32'd2,          32'h7FFFFFFF,    1'b0,3'b010},
    {1'b1,1'b0,1'b1,32'hFFFFFF9C,  32'd7,          32'hFFFFFFF2,    1'b0,3'b100},
    {1'b1,1'b0,1'b0,32'd100,       32'hFFFFFFF9,   32'hFFFFFFF2,    1'b0,3'b000},
    {1'b1,1'b0,1'b1,32'hFFFFFF9C,  32'hFFFFFFF9,   32'd14,          1'b0,3'b010},
    {1'b1,1'b1,1'b1,32'h80000000,  32'hFFFFFFFF,   32'd0,           1'b1,3'b001},
    {1'b0,1'b1,1'b0,32'd5,         32'd0,          32'd0,           1'b1,3'b000},
    {1'b0,1'b0,1'b1,32'd5,         32'd0,          32'd0,           1'b0,3'b001},
    {1'b0,1'b0,1'b1,32'd3,         32'd10,         32'd0,           1'b0,3'b001},
    {1'b0,1'b0,1'b1,32'h80000000,  32'd1,          32'h80000000,    1'b0,3'b100},
    {1'b1,1'b0,1'b1,32'h80000000,  32'd2,          32'hC0000000,    1'b0,3'b100},
    {1'b1,1'b1,1'b0,32'd7,         32'hFFFFFFFF,   32'hFFFFFFF9,    1'b0,3'b000}
  };

  function automatic logic [31:0] mk(input logic [5:0] major, input logic [8:0] minor,
                                     input logic oe, input logic rc);
    return {major, 5'd3, 5'd4, 5'd5, oe, minor, rc};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        output int lat);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; instr = ins; op_a = a; op_b = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!out_valid && lat < 60);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 in_ready", 32'(in_ready), 32'd1);
    chk("R8 out_valid", 32'(out_valid), 32'd0);
    chk("R8 outputs", {quotient[27:0], ovf, cmp_flags}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [102:0] e;
      e = VEC[i];
      run_op(mk(6'd31, e[102] ? 9'd491 : 9'd459, e[101], e[100]), e[99:68], e[67:36], lat);
      chk($sformatf("R4 latency vec %0d", i), 32'(lat), 32'd20);
      chk($sformatf("%s quotient vec %0d", e[102] ? "R3" : "R2", i), quotient, e[35:4]);
      chk($sformatf("R6 ovf vec %0d", i), 32'(ovf), 32'(e[3]));
      chk($sformatf("R7 flags vec %0d", i), 32'(cmp_flags), 32'(e[2:0]));
      @(negedge clk);
      chk("R5 pulse width", 32'(out_valid), 32'd0);
    end

    // R9 outputs hold between results
    held = quotient;
    repeat (7) @(negedge clk);
    chk("R9 hold", quotient, held);

    // R1 foreign major opcode and foreign minor opcode are dropped
    for (int k = 0; k < 2; k++) begin
      int seen;
      seen = 0;
      in_valid = 1'b1;
      instr = (k == 0) ? mk(6'd30, 9'd459, 1'b0, 1'b1) : mk(6'd31, 9'd460, 1'b0, 1'b1);
      op_a = 32'd9; op_b = 32'd3;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (30) begin
        @(negedge clk);
        if (out_valid || !in_ready) seen++;
      end
      chk("R1 ignored opcode", 32'(seen), 32'd0);
      chk("R1 quotient untouched", quotient, held);
    end

    // R5 a request while busy is lost
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; instr = mk(6'd31, 9'd459, 1'b0, 1'b0); op_a = 32'd1000; op_b = 32'd10;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 busy not ready", 32'(in_ready), 32'd0);
    in_valid = 1'b1; instr = mk(6'd31, 9'd491, 1'b0, 1'b1); op_a = 32'd50; op_b = 32'd5;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 5;
    while (!out_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk("R5 first result kept", quotient, 32'd100);
    chk("R5 latency unchanged", 32'(lat), 32'd20);
    repeat (30) @(negedge clk);
    chk("R5 busy request dropped", quotient, 32'd100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule